// File: doc/BRIEF.md
# Thermometer Decoder with Data-Weighted Element Rotation

This block sits between a multibit noise-shaping modulator and a bank of equal-weight unit elements in an audio DAC. Each cycle of the modulator clock (64 times the sample rate) it receives one small unsigned code per channel. It turns each code into an enable pattern with one line per unit element, so that a code of N switches on exactly N elements.

Static element mismatch would otherwise appear as distortion. To spread it out, the block does not always use the same elements for the same code. Each channel keeps a rotation pointer. The enabled elements form a contiguous run that starts at this pointer and wraps around the bank. After each valid code, the pointer moves forward by that code, modulo the element count. As a result, every element is used almost equally often over time. The stereo build has one independent instance per channel, and all instances share a single valid flag.

Top module: `elem_select_dwa`

## Requirements
- R1: While the active-low reset is low, every enable line is 0 and every rotation pointer is 0. The first valid code after reset therefore enables the elements starting at index 0.
- R2: On the clock edge that samples a valid code N on a channel (0 to 15 with the default 4-bit code), that channel's 15-line enable slice takes exactly N ones. The slice is registered, so it is visible one cycle after the input.
- R3: The enabled lines form one contiguous run of length N. It starts at the current pointer P and covers indices P, P+1, … P+N-1 modulo 15, where bit index i of the slice drives element i.
- R4: After a valid code N, the pointer becomes (P + N) mod 15.
- R5: Code 15 enables all 15 lines and leaves the pointer where it was.
- R6: Code 0 enables no line and leaves the pointer where it was.
- R7: When the valid flag is low, the enable slices go to all zeros on the next edge and the pointers hold. The code inputs present during that cycle have no effect.
- R8: Channel c uses code bits [4c+3:4c] and drives enable bits [15c+14:15c]. Its pointer depends only on its own codes.
- R9: Over any run of cycles that starts from reset, the number of cycles each element of a channel has been enabled differs from element to element by at most 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator-rate clock (64 times the sample rate) |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when the codes are valid this cycle |
| in_code | input | NCH*CODE_W | One unsigned code per channel, channel 0 in the low bits |
| out_en | output | NCH*(2**CODE_W-1) | Unit-element enables, channel 0 in the low bits |

## Verification
The block is driven with several kinds of input, and each kind separates a different class of fault:
- A short, hand-picked code sequence makes the pointer wrap at different offsets on the two channels. It separates correct modular advance from an off-by-one or an unwrapped pointer.
- Code 15 and code 0 show whether the pointer is left in place at the ends of the range.
- Invalid cycles that carry non-zero codes show whether the valid flag is ignored.
- A long random stream, with occasional invalid cycles, is scored against a model that computes the expected pattern for every cycle. The same stream is also used to count how often each element is enabled, which exposes any rotation scheme that does not balance element use.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
    localparam int DEF_CODE_W = 4;
    localparam int DEF_NCH    = 2;

    // number of unit elements addressed by a code of the given width
    function automatic int elem_count(input int code_w);
        return (1 << code_w) - 1;
    endfunction
endpackage

// File: rtl/dwa_therm_dec.sv
module dwa_therm_dec #(
    parameter int CODE_W   = 4,
    parameter int NUM_ELEM = 15
) (
    input  logic [CODE_W-1:0]   code,
    output logic [NUM_ELEM-1:0] therm
);
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_line
        assign therm[g] = (code > CODE_W'(g));
    end
endmodule

// File: rtl/dwa_rotator.sv
module dwa_rotator #(
    parameter int NUM_ELEM = 15,
    parameter int PTR_W    = 4
) (
    input  logic [NUM_ELEM-1:0] din,
    input  logic [PTR_W-1:0]    rot,
    output logic [NUM_ELEM-1:0] dout
);
    localparam int IW = PTR_W + 1;

    // element g takes thermometer position (g - rot) mod NUM_ELEM
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
        logic [IW-1:0] src;
        always_comb begin
            src = IW'(g) + IW'(NUM_ELEM) - IW'(rot);
            if (src >= IW'(NUM_ELEM)) begin
                src = src - IW'(NUM_ELEM);
            end
            dout[g] = din[src[PTR_W-1:0]];
        end
    end
endmodule

// File: rtl/dwa_channel.sv
module dwa_channel #(
    parameter int CODE_W   = 4,
    parameter int NUM_ELEM = 15,
    parameter int PTR_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic [CODE_W-1:0]   code,
    output logic [NUM_ELEM-1:0] en
);
    localparam int SW = ((PTR_W > CODE_W) ? PTR_W : CODE_W) + 1;

    typedef struct packed {
        logic [PTR_W-1:0]    ptr;
        logic [NUM_ELEM-1:0] en;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [NUM_ELEM-1:0] therm;
    logic [NUM_ELEM-1:0] rotated;
    logic [SW-1:0]       ptr_sum;

    dwa_therm_dec #(.CODE_W(CODE_W), .NUM_ELEM(NUM_ELEM)) u_dec (
        .code  (code),
        .therm (therm)
    );

    dwa_rotator #(.NUM_ELEM(NUM_ELEM), .PTR_W(PTR_W)) u_rot (
        .din  (therm),
        .rot  (st_q.ptr),
        .dout (rotated)
    );

    always_comb begin
        st_d    = st_q;
        ptr_sum = SW'(st_q.ptr) + SW'(code);
        if (ptr_sum >= SW'(NUM_ELEM)) begin
            ptr_sum = ptr_sum - SW'(NUM_ELEM);
        end
        if (valid) begin
            st_d.en  = rotated;
            st_d.ptr = ptr_sum[PTR_W-1:0];
        end else begin
            st_d.en  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en = st_q.en;
endmodule

// File: rtl/elem_select_dwa.sv
module elem_select_dwa #(
    parameter int NCH    = dwa_pkg::DEF_NCH,
    parameter int CODE_W = dwa_pkg::DEF_CODE_W
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          in_valid,
    input  logic [NCH*CODE_W-1:0]                         in_code,
    output logic [NCH*dwa_pkg::elem_count(CODE_W)-1:0]    out_en
);
    localparam int NUM_ELEM = dwa_pkg::elem_count(CODE_W);
    localparam int PTR_W    = $clog2(NUM_ELEM);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dwa_channel #(
            .CODE_W   (CODE_W),
            .NUM_ELEM (NUM_ELEM),
            .PTR_W    (PTR_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (in_valid),
            .code  (in_code[c*CODE_W +: CODE_W]),
            .en    (out_en[c*NUM_ELEM +: NUM_ELEM])
        );
    end
endmodule

// File: rtl/elem_select_dwa_chk.sv
module elem_select_dwa_chk #(
    parameter int NCH      = 2,
    parameter int CODE_W   = 4,
    parameter int NUM_ELEM = 15
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [NCH*CODE_W-1:0]      in_code,
    input logic [NCH*NUM_ELEM-1:0]    out_en
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_en == '0));

    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (out_en == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R2
        count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> ($countones(out_en[c*NUM_ELEM +: NUM_ELEM])
                          == int'($past(in_code[c*CODE_W +: CODE_W]))));

        // R5
        full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (in_code[c*CODE_W +: CODE_W] == '1))
            |=> (out_en[c*NUM_ELEM +: NUM_ELEM] == '1));

        // R6
        zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (in_code[c*CODE_W +: CODE_W] == '0))
            |=> (out_en[c*NUM_ELEM +: NUM_ELEM] == '0));
    end
endmodule

bind elem_select_dwa elem_select_dwa_chk #(
    .NCH      (NCH),
    .CODE_W   (CODE_W),
    .NUM_ELEM (NUM_ELEM)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_code  (in_code),
    .out_en   (out_en)
);

// File: tb/elem_select_dwa_test.sv
module elem_select_dwa_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int CW  = 4;
    localparam int NE  = 15;

    typedef struct {
        logic [NCH*NE-1:0] en;
        logic [NCH*CW-1:0] code;
        logic              valid;
        string             tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [NCH*CW-1:0] in_code = '0;
    logic [NCH*NE-1:0] out_en;

    item_t exp_q[$];
    int    mptr[NCH];
    int    cnt[NCH][NE];
    bit    count_on = 1'b0;
    int    n_tests = 0;
    int    n_fail = 0;

    elem_select_dwa #(.NCH(NCH), .CODE_W(CW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_code  (in_code),
        .out_en   (out_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NE-1:0] pattern(int p, int c);
        logic [NE-1:0] r;
        for (int i = 0; i < NE; i++) begin
            r[i] = (((i - p + NE) % NE) < c);
        end
        return r;
    endfunction

    task automatic drive(bit v, int c0, int c1, string tag);
        item_t it;
        int cs[NCH];
        cs[0] = c0;
        cs[1] = c1;
        @(negedge clk);
        in_valid = v;
        for (int ch = 0; ch < NCH; ch++) begin
            in_code[ch*CW +: CW] = CW'(cs[ch]);
            if (v) begin
                it.en[ch*NE +: NE] = pattern(mptr[ch], cs[ch]);
                mptr[ch] = (mptr[ch] + cs[ch]) % NE;
            end else begin
                it.en[ch*NE +: NE] = '0;
            end
        end
        it.code  = in_code;
        it.valid = v;
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        for (int ch = 0; ch < NCH; ch++) mptr[ch] = 0;
        repeat (3) @(negedge clk);
        check(out_en == '0, "R1", "enables during reset", longint'(out_en), 0);
        rst_n = 1'b1;
    endtask

    // scoreboard monitor: compares one registered result per driven item
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (count_on) begin
            for (int ch = 0; ch < NCH; ch++)
                for (int e = 0; e < NE; e++)
                    if (out_en[ch*NE + e]) cnt[ch][e]++;
        end
        if (exp_q.size() != 0) begin
            item_t it;
            it = exp_q.pop_front();
            for (int ch = 0; ch < NCH; ch++) begin
                logic [NE-1:0] act_s;
                logic [NE-1:0] exp_s;
                act_s = out_en[ch*NE +: NE];
                exp_s = it.en[ch*NE +: NE];
                check(act_s == exp_s, it.tag, $sformatf("pattern ch%0d", ch),
                      longint'(act_s), longint'(exp_s));
                if (it.valid) begin
                    check($countones(act_s) == int'(it.code[ch*CW +: CW]), "R2",
                          $sformatf("line count ch%0d", ch),
                          longint'($countones(act_s)), longint'(it.code[ch*CW +: CW]));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < NCH; ch++) mptr[ch] = 0;
        do_reset();

        // R1: first code starts at element 0
        drive(1, 3, 5, "R1");
        // R3 R4: pointer advance with wrap at different offsets
        drive(1, 4, 11, "R4");
        drive(1, 7, 1, "R4");
        drive(1, 9, 14, "R3");
        drive(1, 2, 6, "R4");
        // R5: full scale keeps pointer
        drive(1, 15, 15, "R5");
        drive(1, 5, 3, "R5");
        // R6: zero code keeps pointer
        drive(1, 0, 0, "R6");
        drive(1, 6, 8, "R6");
        // R7: invalid cycle with non-zero codes ignored
        drive(0, 9, 12, "R7");
        drive(0, 15, 7, "R7");
        drive(1, 2, 4, "R7");
        // R8: one channel busy, the other idle at zero
        for (int k = 0; k < 20; k++) drive(1, $urandom_range(15), 0, "R8");
        for (int k = 0; k < 20; k++) drive(1, 0, $urandom_range(15), "R8");
        // R2: random mix
        for (int k = 0; k < 200; k++)
            drive(($urandom_range(9) != 0), $urandom_range(15), $urandom_range(15), "R2");
        drain();

        // mid-run reset then R1 again
        do_reset();
        drive(1, 6, 2, "R1");
        drain();

        // R9: long run from reset, balance of element use
        do_reset();
        for (int ch = 0; ch < NCH; ch++)
            for (int e = 0; e < NE; e++) cnt[ch][e] = 0;
        @(negedge clk);
        count_on = 1'b1;
        for (int k = 0; k < 3000; k++)
            drive(($urandom_range(9) != 0), $urandom_range(15), $urandom_range(15), "R9");
        drain();
        count_on = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin
            int mn;
            int mx;
            mn = cnt[ch][0];
            mx = cnt[ch][0];
            for (int e = 1; e < NE; e++) begin
                if (cnt[ch][e] < mn) mn = cnt[ch][e];
                if (cnt[ch][e] > mx) mx = cnt[ch][e];
            end
            check((mx - mn) <= 1, "R9", $sformatf("use spread ch%0d", ch),
                  longint'(mx - mn), 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule